// File: doc/BRIEF.md
# Interrupt Distributor State Registers

This block keeps the configuration and live state of every interrupt source that a distributor serves. For each source it holds an enable bit, a latched pending bit, an active bit, a group bit, an 8-bit priority (a smaller number outranks a larger one), an 8-bit mask of destination processors and an edge/level trigger select. Software reaches all of it through a flat 32-bit register bus. Enable, pending and active each have two address windows: one where writing ones sets bits and one where writing ones clears them. Writing zeros in either window does nothing.

Hardware request lines are sampled on every clock. An edge-configured source latches pending on a rising input. A level-configured source reports pending for as long as its input is high and it is not in service. A separate acknowledge port moves a chosen source into service, and an end-of-service port takes it out again. A status port gives the pending and active state of any one source without a bus read. Arbitration between processors and software-generated requests are handled elsewhere.

Top module: `irq_dist_state`

## Requirements
- R1: After reset:
  - all enable, pending, active, group, priority and destination state reads 0;
  - the control bit reads 0;
  - the trigger fields of IDs 0–15 read 2'b10 and all other trigger fields read 0.
- R2: The enable windows are 0x100 (set) and 0x180 (clear). Source n sits at bit n%32 of the word at base+4*(n/32). Writing 1 sets or clears only the addressed bits, and writing 0 has no effect. Both windows read back the current enable state.
- R3: Pending uses the same bit layout, with set at 0x200 and clear at 0x280. Active uses it with set at 0x300 and clear at 0x380. Both obey the same write-one and read-back rules as R2.
- R4: Group bits sit at 0x080 in the same bit layout and are plain read/write bits. 0 selects group 0 (secure) and 1 selects group 1 (non-secure).
- R5: Priority for source n is byte n%4, bits [8*(n%4)+7 : 8*(n%4)], of the word at 0x400+4*(n/4). The destination mask uses the same layout at 0x800, where bit k of the mask selects processor k. Both are plain read/write fields.
- R6: The trigger field of source n is bits [2*(n%16)+1 : 2*(n%16)] of the word at 0xC00+4*(n/16):
  - its upper bit is 1 for edge and 0 for level;
  - its lower bit always reads 0;
  - IDs 0–15 are fixed at edge, and writes to them have no effect.
- R7: An edge source latches pending on a rising edge of its request input. Pending shows on the second clock edge after the input rises and stays set after the input falls.
- R8: A level source reads pending from the first clock edge after its input rises, as long as it is not active. It reads not pending from the first clock edge after the input falls, unless pending was set by software.
- R9: An acknowledge of source n sets its active bit and clears its latched pending bit at the next clock edge. A level source reads not pending while it is active.
- R10: An end-of-service for source n clears its active bit at the next clock edge. If it is a level source whose input is still high, it then reads pending again.
- R11: The status port returns, combinationally for the selected source, pending in bit 0 and active in bit 1.
- R12: The register at 0x000 holds a read/write control bit in bit 0. The register at 0x004 reads NUM_IRQ/32-1 in bits [4:0]. Reads of words beyond the implemented sources return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_in | input | NUM_IRQ | Hardware request lines, one per source |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDW | Source being acknowledged |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_id | input | IDW | Source whose service ends |
| stat_id | input | IDW | Source selected for the status port |
| stat_out | output | 2 | {active, pending} of stat_id |

## Verification
A slot with corrupt state shows up at once on the status port and on the next read of its window. A wrong enable or active bit is visible in both its set and its clear window. A priority or destination byte in the wrong lane shows up as a wrong byte in the neighbouring source's word. A trigger field that is wrongly writable shows up as soon as a write to the fixed word is read back, and a lost edge shows up two cycles after the input rises. Acknowledge and end-of-service faults appear on the status port one clock after the strobe.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int PRIO_W = 8;
  localparam int TGT_W  = 8;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_GRP,
    RG_ENS,  RG_ENC,  RG_PDS,  RG_PDC,
    RG_ACS,  RG_ACC,  RG_PRI,  RG_TGT, RG_CFG
  } region_e;

  // Pending as seen by software for one source
  function automatic logic eff_pending(logic latched, logic edge_mode,
                                       logic line, logic active);
    return latched | (~edge_mode & line & ~active);
  endfunction

  // Word index and lane of a source in each packing
  function automatic int word_of(int id, int per_word);
    return id / per_word;
  endfunction

  function automatic int lane_of(int id, int per_word);
    return id % per_word;
  endfunction

endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [7:0]        word,
  output logic              hit
);
  localparam int W32 = NUM_IRQ / 32;
  localparam int W4  = NUM_IRQ / 4;
  localparam int W16 = NUM_IRQ / 16;

  int limit;

  always_comb begin
    region = RG_NONE;
    word   = addr[9:2];
    limit  = 0;
    unique case (addr[11:10])
      2'b00: begin
        word  = {3'b000, addr[6:2]};
        limit = W32;
        unique case (addr[9:7])
          3'd0: begin
            if (addr[6:2] == 5'd0) region = RG_CTRL;
            else if (addr[6:2] == 5'd1) region = RG_TYPE;
          end
          3'd1: region = RG_GRP;
          3'd2: region = RG_ENS;
          3'd3: region = RG_ENC;
          3'd4: region = RG_PDS;
          3'd5: region = RG_PDC;
          3'd6: region = RG_ACS;
          default: region = RG_ACC;
        endcase
      end
      2'b01: begin region = RG_PRI; limit = W4;  end
      2'b10: begin region = RG_TGT; limit = W4;  end
      default: begin region = RG_CFG; limit = W16; end
    endcase
    if (region == RG_CTRL || region == RG_TYPE) hit = 1'b1;
    else hit = (region != RG_NONE) && (int'({1'b0, word}) < limit);
  end

endmodule

// File: rtl/dist_slot.sv
module dist_slot
  import irq_dist_pkg::*;
#(
  parameter bit CFG_LOCKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              grp_wr,
  input  logic              grp_val,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              pd_set,
  input  logic              pd_clr,
  input  logic              ac_set,
  input  logic              ac_clr,
  input  logic              prio_wr,
  input  logic [PRIO_W-1:0] prio_val,
  input  logic              tgt_wr,
  input  logic [TGT_W-1:0]  tgt_val,
  input  logic              cfg_wr,
  input  logic              cfg_edge_val,
  input  logic              ack,
  input  logic              eoi,
  output logic              grp,
  output logic              en,
  output logic              pend,
  output logic              act,
  output logic [PRIO_W-1:0] prio,
  output logic [TGT_W-1:0]  tgt,
  output logic              edge_mode,
  output logic              rise_evt
);
  logic line_q, line_q2, pend_q;
  logic pend_n, act_n;

  assign rise_evt = line_q & ~line_q2;

  generate
    if (CFG_LOCKED) begin : g_fixed
      assign edge_mode = 1'b1;
    end else begin : g_prog
      logic edge_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      edge_q <= 1'b0;
        else if (cfg_wr) edge_q <= cfg_edge_val;
      end
      assign edge_mode = edge_q;
    end
  endgenerate

  always_comb begin
    pend_n = pend_q;
    if (ack) pend_n = 1'b0;
    if (edge_mode && rise_evt) pend_n = 1'b1;
    if (pd_set) pend_n = 1'b1;
    if (pd_clr) pend_n = 1'b0;
    act_n = act;
    if (ack)    act_n = 1'b1;
    if (eoi)    act_n = 1'b0;
    if (ac_set) act_n = 1'b1;
    if (ac_clr) act_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      line_q2 <= 1'b0;
      pend_q  <= 1'b0;
      act     <= 1'b0;
      en      <= 1'b0;
      grp     <= 1'b0;
      prio    <= '0;
      tgt     <= '0;
    end else begin
      line_q  <= line_in;
      line_q2 <= line_q;
      pend_q  <= pend_n;
      act     <= act_n;
      if (en_set)  en   <= 1'b1;
      if (en_clr)  en   <= 1'b0;
      if (grp_wr)  grp  <= grp_val;
      if (prio_wr) prio <= prio_val;
      if (tgt_wr)  tgt  <= tgt_val;
    end
  end

  assign pend = eff_pending(pend_q, edge_mode, line_q, act);

endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
  import irq_dist_pkg::*;
#(
  parameter  int NUM_IRQ = 64,
  localparam int IDW     = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ack_valid,
  input  logic [IDW-1:0]     ack_id,
  input  logic               eoi_valid,
  input  logic [IDW-1:0]     eoi_id,
  input  logic [IDW-1:0]     stat_id,
  output logic [1:0]         stat_out
);
  localparam int          LOCKED_IDS = 16;
  localparam logic [4:0]  TYPE_VAL   = 5'(NUM_IRQ / 32 - 1);

  region_e    region;
  logic [7:0] word;
  logic       hit, wr_hit;
  logic       ctrl_en;

  logic [NUM_IRQ-1:0]        grp_v, en_v, pend_v, act_v, edge_v, rise_v;
  logic [NUM_IRQ*PRIO_W-1:0] prio_v;
  logic [NUM_IRQ*TGT_W-1:0]  tgt_v;

  dist_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr(bus_addr), .region(region), .word(word), .hit(hit)
  );

  assign wr_hit = bus_we & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_en <= 1'b0;
    else if (wr_hit && region == RG_CTRL) ctrl_en <= bus_wdata[0];
  end

  generate
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_slot
      localparam int WB = word_of(n, 32);
      localparam int LB = lane_of(n, 32);
      localparam int WP = word_of(n, 4);
      localparam int LP = lane_of(n, 4);
      localparam int WC = word_of(n, 16);
      localparam int LC = lane_of(n, 16);
      logic bw, pw, cw;
      assign bw = wr_hit && (word == 8'(WB));
      assign pw = wr_hit && (word == 8'(WP));
      assign cw = wr_hit && (word == 8'(WC));

      dist_slot #(.CFG_LOCKED(n < LOCKED_IDS)) u_slot (
        .clk(clk), .rst_n(rst_n), .line_in(irq_in[n]),
        .grp_wr(bw && region == RG_GRP), .grp_val(bus_wdata[LB]),
        .en_set(bw && region == RG_ENS && bus_wdata[LB]),
        .en_clr(bw && region == RG_ENC && bus_wdata[LB]),
        .pd_set(bw && region == RG_PDS && bus_wdata[LB]),
        .pd_clr(bw && region == RG_PDC && bus_wdata[LB]),
        .ac_set(bw && region == RG_ACS && bus_wdata[LB]),
        .ac_clr(bw && region == RG_ACC && bus_wdata[LB]),
        .prio_wr(pw && region == RG_PRI), .prio_val(bus_wdata[PRIO_W*LP +: PRIO_W]),
        .tgt_wr(pw && region == RG_TGT), .tgt_val(bus_wdata[TGT_W*LP +: TGT_W]),
        .cfg_wr(cw && region == RG_CFG), .cfg_edge_val(bus_wdata[2*LC+1]),
        .ack(ack_valid && ack_id == IDW'(n)),
        .eoi(eoi_valid && eoi_id == IDW'(n)),
        .grp(grp_v[n]), .en(en_v[n]), .pend(pend_v[n]), .act(act_v[n]),
        .prio(prio_v[PRIO_W*n +: PRIO_W]), .tgt(tgt_v[TGT_W*n +: TGT_W]),
        .edge_mode(edge_v[n]), .rise_evt(rise_v[n])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      if (region == RG_CTRL) bus_rdata[0] = ctrl_en;
      else if (region == RG_TYPE) bus_rdata[4:0] = TYPE_VAL;
      else begin
        for (int n = 0; n < NUM_IRQ; n++) begin
          if (word == 8'(n / 32)) begin
            unique case (region)
              RG_GRP:         bus_rdata[n % 32] = grp_v[n];
              RG_ENS, RG_ENC: bus_rdata[n % 32] = en_v[n];
              RG_PDS, RG_PDC: bus_rdata[n % 32] = pend_v[n];
              RG_ACS, RG_ACC: bus_rdata[n % 32] = act_v[n];
              default: ;
            endcase
          end
          if (word == 8'(n / 4)) begin
            if (region == RG_PRI) bus_rdata[PRIO_W*(n % 4) +: PRIO_W] = prio_v[PRIO_W*n +: PRIO_W];
            if (region == RG_TGT) bus_rdata[TGT_W*(n % 4) +: TGT_W]  = tgt_v[TGT_W*n +: TGT_W];
          end
          if (word == 8'(n / 16) && region == RG_CFG)
            bus_rdata[2*(n % 16)+1] = edge_v[n];
        end
      end
    end
  end

  always_comb begin
    stat_out = 2'b00;
    if (int'(stat_id) < NUM_IRQ) stat_out = {act_v[stat_id], pend_v[stat_id]};
  end

endmodule

// File: rtl/irq_dist_state_chk.sv
module irq_dist_state_chk
  import irq_dist_pkg::*;
#(
  parameter  int NUM_IRQ = 64,
  localparam int IDW     = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               ack_valid,
  input logic [IDW-1:0]     ack_id,
  input logic               eoi_valid,
  input logic [IDW-1:0]     eoi_id,
  input logic [NUM_IRQ-1:0] act_v,
  input logic [NUM_IRQ-1:0] en_v,
  input logic [NUM_IRQ-1:0] edge_v
);

  AST_ACK_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !bus_we && !(eoi_valid && eoi_id == ack_id) |=> act_v[$past(ack_id)]); // R9

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !bus_we |=> !act_v[$past(eoi_id)]); // R10

  AST_EN_SET_W1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 12'h100 |=> ((en_v[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_EN_CLR_W1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 12'h180 |=> ((en_v[31:0] & $past(bus_wdata)) == 32'd0)); // R2

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 12'hC00 |=> $stable(edge_v[15:0])); // R6

endmodule

bind irq_dist_state irq_dist_state_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ack_valid(ack_valid), .ack_id(ack_id),
  .eoi_valid(eoi_valid), .eoi_id(eoi_id), .act_v(act_v), .en_v(en_v),
  .edge_v(edge_v)
);

// File: tb/sim_irq_dist_state.sv
module sim_irq_dist_state;
  localparam int N   = 64;
  localparam int IDW = $clog2(N);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_we = 1'b0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [N-1:0]   irq_in = '0;
  logic           ack_valid = 1'b0;
  logic [IDW-1:0] ack_id = '0;
  logic           eoi_valid = 1'b0;
  logic [IDW-1:0] eoi_id = '0;
  logic [IDW-1:0] stat_id = '0;
  logic [1:0]     stat_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_dist_state #(.NUM_IRQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id), .stat_id(stat_id), .stat_out(stat_out)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic st_chk(input int id, input logic [1:0] exp, input string req);
    stat_id = IDW'(id);
    #1;
    checks++;
    if (stat_out !== exp) begin
      errors++;
      $display("FAIL %s id %0d: got %b expected %b", req, id, stat_out, exp);
    end
  endtask

  task automatic pulse_ack(input int id);
    @(negedge clk); ack_valid = 1'b1; ack_id = IDW'(id);
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic pulse_eoi(input int id);
    @(negedge clk); eoi_valid = 1'b1; eoi_id = IDW'(id);
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  function automatic logic [7:0] prio_of(int n);
    return 8'((n * 37 + 5) & 8'hFF);
  endfunction
  function automatic logic [7:0] tgt_of(int n);
    return 8'((n * 13 + 1) & 8'hFF);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] model;
    logic [31:0]  w;
    logic [31:0]  pset, aset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R12: reset state
    rd_chk(12'h000, 32'h0, "R1");
    rd_chk(12'h004, 32'h1, "R12");
    for (int w2 = 0; w2 < 2; w2++) begin
      rd_chk(12'(12'h080 + 4*w2), 32'h0, "R1");
      rd_chk(12'(12'h100 + 4*w2), 32'h0, "R1");
      rd_chk(12'(12'h200 + 4*w2), 32'h0, "R1");
      rd_chk(12'(12'h300 + 4*w2), 32'h0, "R1");
    end
    for (int w2 = 0; w2 < 16; w2++) begin
      rd_chk(12'(12'h400 + 4*w2), 32'h0, "R1");
      rd_chk(12'(12'h800 + 4*w2), 32'h0, "R1");
    end
    rd_chk(12'hC00, 32'hAAAA_AAAA, "R1");
    for (int w2 = 1; w2 < 4; w2++) rd_chk(12'(12'hC00 + 4*w2), 32'h0, "R1");

    // R2: enable set sweep, one bit at a time, then clear every even id
    model = '0;
    for (int n = 0; n < N; n++) begin
      wr(12'(12'h100 + 4*(n/32)), 32'h1 << (n % 32));
      model[n] = 1'b1;
      rd_chk(12'(12'h100 + 4*(n/32)), model[32*(n/32) +: 32], "R2");
      rd_chk(12'(12'h180 + 4*(n/32)), model[32*(n/32) +: 32], "R2");
    end
    wr(12'h100, 32'h0);
    wr(12'h184, 32'h0);
    rd_chk(12'h100, 32'hFFFF_FFFF, "R2");
    rd_chk(12'h104, 32'hFFFF_FFFF, "R2");
    for (int n = 0; n < N; n += 2) begin
      wr(12'(12'h180 + 4*(n/32)), 32'h1 << (n % 32));
      model[n] = 1'b0;
    end
    rd_chk(12'h180, model[31:0], "R2");
    rd_chk(12'h104, model[63:32], "R2");

    // R3: pending and active windows, then the status port sweep (R11)
    pset = 32'hA5A5_0F0F;
    aset = 32'h00FF_3C01;
    wr(12'h204, pset);
    wr(12'h304, aset);
    wr(12'h200, 32'h0);
    rd_chk(12'h204, pset, "R3");
    rd_chk(12'h284, pset, "R3");
    rd_chk(12'h304, aset, "R3");
    rd_chk(12'h384, aset, "R3");
    rd_chk(12'h200, 32'h0, "R3");
    for (int n = 0; n < N; n++) begin
      if (n < 32) st_chk(n, 2'b00, "R11");
      else st_chk(n, {aset[n-32], pset[n-32]}, "R11");
    end
    wr(12'h284, 32'h0000_FFFF);
    rd_chk(12'h204, pset & 32'hFFFF_0000, "R3");
    wr(12'h384, 32'h0000_0001);
    rd_chk(12'h304, aset & 32'hFFFF_FFFE, "R3");
    wr(12'h284, 32'hFFFF_FFFF);
    wr(12'h384, 32'hFFFF_FFFF);
    rd_chk(12'h204, 32'h0, "R3");
    rd_chk(12'h304, 32'h0, "R3");

    // R4: group bits
    wr(12'h080, 32'h1234_8765);
    wr(12'h084, 32'hFEDC_0001);
    rd_chk(12'h080, 32'h1234_8765, "R4");
    rd_chk(12'h084, 32'hFEDC_0001, "R4");

    // R5: priority and destination byte packing
    for (int w2 = 0; w2 < 16; w2++) begin
      w = {prio_of(4*w2+3), prio_of(4*w2+2), prio_of(4*w2+1), prio_of(4*w2)};
      wr(12'(12'h400 + 4*w2), w);
      w = {tgt_of(4*w2+3), tgt_of(4*w2+2), tgt_of(4*w2+1), tgt_of(4*w2)};
      wr(12'(12'h800 + 4*w2), w);
    end
    for (int w2 = 0; w2 < 16; w2++) begin
      rd_chk(12'(12'h400 + 4*w2),
             {prio_of(4*w2+3), prio_of(4*w2+2), prio_of(4*w2+1), prio_of(4*w2)}, "R5");
      rd_chk(12'(12'h800 + 4*w2),
             {tgt_of(4*w2+3), tgt_of(4*w2+2), tgt_of(4*w2+1), tgt_of(4*w2)}, "R5");
    end

    // R6: trigger configuration
    wr(12'hC00, 32'h0);
    rd_chk(12'hC00, 32'hAAAA_AAAA, "R6");
    wr(12'hC04, 32'hFFFF_FFFF);
    rd_chk(12'hC04, 32'hAAAA_AAAA, "R6");
    wr(12'hC0C, 32'h5555_5555);
    rd_chk(12'hC0C, 32'h0, "R6");
    wr(12'hC08, 32'h0000_0008);
    rd_chk(12'hC08, 32'h0000_0008, "R6");

    // R7: edge source 20 latches on a rising input
    @(negedge clk); irq_in[20] = 1'b1;
    @(negedge clk); st_chk(20, 2'b00, "R7");
    @(negedge clk); st_chk(20, 2'b01, "R7");
    irq_in[20] = 1'b0;
    repeat (3) @(negedge clk);
    st_chk(20, 2'b01, "R7");

    // R9 / R10 on the edge source
    pulse_ack(20);
    st_chk(20, 2'b10, "R9");
    pulse_eoi(20);
    st_chk(20, 2'b00, "R10");

    // R8: level source 40 follows the input
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk); st_chk(40, 2'b01, "R8");
    irq_in[40] = 1'b0;
    @(negedge clk); st_chk(40, 2'b00, "R8");

    // R9 / R10 on the level source with the input held high
    irq_in[40] = 1'b1;
    @(negedge clk); st_chk(40, 2'b01, "R8");
    pulse_ack(40);
    st_chk(40, 2'b10, "R9");
    pulse_eoi(40);
    st_chk(40, 2'b01, "R10");
    irq_in[40] = 1'b0;
    @(negedge clk); st_chk(40, 2'b00, "R8");

    // R12: control bit and out-of-range reads
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk(12'h000, 32'h1, "R12");
    wr(12'h000, 32'h0);
    rd_chk(12'h000, 32'h0, "R12");
    rd_chk(12'h108, 32'h0, "R12");
    rd_chk(12'h440, 32'h0, "R12");
    rd_chk(12'hC10, 32'h0, "R12");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule